// File: doc/BRIEF.md
# Clos First-Stage Box Routing Controller

This block computes the switch setting of one input box in a rearrangeable three-stage Clos network with `N_IN` pins per box, `N_IN` input boxes, `N_IN` output boxes and `M = N_IN + N_IN/2 - 1` middle-stage boxes. It keeps an occupancy map for the whole first stage. Each row of the map is a first-stage out-pin index, which is also a middle-stage box. Each column is an output box. A bit set to 1 means that path is still free.

A request names one input box and gives the destination output-pin number of each of its pins. The controller first frees the paths that box committed last time. It then routes the pins one per cycle. The next pin is always the one with the fewest free rows, and the row it takes is picked from the top or the bottom of the column depending on the parity of the output box. The controller then commits the new paths and reports the out-pin chosen for every input pin.

Only the requesting box's entries change. Every other box keeps its paths, so its traffic is unaffected.

Top module: `clos_box_router`

## Requirements
- R1: After reset, every path in the occupancy map is free, no box holds an assignment, and `busy`, `done` and `err` are low.
- R2: A `start` sampled while idle raises `busy` on that edge. `done` pulses high for exactly one cycle, `N_IN+2` clock edges after the edge that sampled `start`. `busy` is low whenever `done` is high.
- R3: `start` has no effect while `busy` is high. `route` and `err` hold their values from one `done` until the next request is processed.
- R4: When `err` is low, the pins of one box receive pairwise distinct out-pins, each below `M`. Out-pin of pin p is `route[p*MW +: MW]`, with `MW = $clog2(M)`.
- R5: The next pin routed is the unrouted pin with the fewest alternatives. An alternative is a row that is free in the pin's destination column and not yet taken in this request. On a tie, the lower-numbered pin goes first.
- R6: For an even output box the lowest-numbered alternative row is taken. For an odd output box the highest-numbered one is taken.
- R7: At the end of a request, each routed pin's path (row, output box) is marked occupied, so later requests from other boxes cannot take it.
- R8: At the start of a request, the paths the same box committed in its previous request are freed before any pin is routed.
- R9: A request changes only the occupancy entries belonging to the requesting box. Paths of all other boxes remain occupied.
- R10: A pin with zero alternatives sets `err`, reports out-pin 0 and commits no path. `err` is cleared when the next request is accepted.
- R11: Pin p's destination is `dest[p*DW +: DW]` with `DW = 2*log2(N_IN)`. Its output box is the destination divided by `N_IN`, which is the upper `log2(N_IN)` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| box | input | log2(N_IN) | Index of the input box to reroute |
| dest | input | N_IN*DW | Destination output-pin number per input pin |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | At least one pin found no free path |
| route | output | N_IN*MW | Out-pin chosen for each input pin |

## Verification
A request accepted at one edge is released on the next edge and routed over the following `N_IN` edges. It is committed on the edge after that, so `done` and the new `route` and `err` become visible `N_IN+2` edges after the accepting edge. The bench drives inputs on falling edges and counts rising edges from the accepting one. It samples on falling edges, confirms `done` arrives on exactly the expected edge, and reads `route` and `err` there and one cycle later. Expected routes are worked out by hand from the occupancy each earlier request leaves behind. The sequences are chosen so that a wrong pin order, a wrong row direction, a missing release or a disturbed neighbour each change a reported out-pin or `err`.

// File: rtl/clos_box_router.sv
module clos_box_router #(
  parameter int N_IN = 4,
  localparam int LOGN = $clog2(N_IN),
  localparam int DW = 2 * LOGN,
  localparam int M = N_IN + N_IN / 2 - 1,
  localparam int MW = $clog2(M),
  localparam int CW = $clog2(M + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [LOGN-1:0]      box,
  input  logic [N_IN*DW-1:0]   dest,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic [N_IN*MW-1:0]   route
);

  typedef enum logic [1:0] {S_IDLE, S_FREE, S_ROUTE, S_COMMIT} state_t;
  state_t state_q;

  logic [M-1:0]      free_q [N_IN];
  logic [MW-1:0]     t_row  [N_IN][N_IN];
  logic [LOGN-1:0]   t_col  [N_IN][N_IN];
  logic [N_IN-1:0]   t_vld  [N_IN];

  logic [LOGN-1:0]   box_q;
  logic [N_IN*DW-1:0] dst_q;
  logic [M-1:0]      taken_q;
  logic [N_IN-1:0]   done_pins_q;
  logic [N_IN-1:0]   pvld_q;
  logic [LOGN:0]     step_q;

  logic [LOGN-1:0]   col   [N_IN];
  logic [M-1:0]      avail [N_IN];
  logic [CW-1:0]     nalt  [N_IN];
  logic [LOGN-1:0]   sel_p;
  logic [CW-1:0]     sel_n;
  logic [MW-1:0]     sel_row;
  logic [M-1:0]      sel_av;

  always_comb begin
    for (int p = 0; p < N_IN; p++) begin
      col[p]   = dst_q[p*DW+LOGN +: LOGN];
      avail[p] = free_q[col[p]] & ~taken_q;
      nalt[p]  = CW'($countones(avail[p]));
    end
    sel_p = '0;
    sel_n = CW'(M + 1);
    for (int p = N_IN - 1; p >= 0; p--)
      if (!done_pins_q[p] && nalt[p] <= sel_n) begin
        sel_p = LOGN'(p);
        sel_n = nalt[p];
      end
    sel_av  = avail[sel_p];
    sel_row = '0;
    if (col[sel_p][0]) begin
      for (int i = 0; i < M; i++)
        if (sel_av[i]) sel_row = MW'(i);
    end else begin
      for (int i = M - 1; i >= 0; i--)
        if (sel_av[i]) sel_row = MW'(i);
    end
  end

  assign busy = (state_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      box_q       <= '0;
      dst_q       <= '0;
      taken_q     <= '0;
      done_pins_q <= '0;
      pvld_q      <= '0;
      step_q      <= '0;
      done        <= 1'b0;
      err         <= 1'b0;
      route       <= '0;
      for (int j = 0; j < N_IN; j++) begin
        free_q[j] <= '1;
        t_vld[j]  <= '0;
        for (int p = 0; p < N_IN; p++) begin
          t_row[j][p] <= '0;
          t_col[j][p] <= '0;
        end
      end
    end else begin
      done <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          box_q   <= box;
          dst_q   <= dest;
          err     <= 1'b0;
          state_q <= S_FREE;
        end
        S_FREE: begin
          for (int p = 0; p < N_IN; p++)
            if (t_vld[box_q][p])
              free_q[t_col[box_q][p]][t_row[box_q][p]] <= 1'b1;
          t_vld[box_q] <= '0;
          taken_q      <= '0;
          done_pins_q  <= '0;
          pvld_q       <= '0;
          step_q       <= '0;
          route        <= '0;
          state_q      <= S_ROUTE;
        end
        S_ROUTE: begin
          done_pins_q[sel_p] <= 1'b1;
          if (sel_n == '0) begin
            err <= 1'b1;
          end else begin
            route[sel_p*MW +: MW] <= sel_row;
            taken_q[sel_row]      <= 1'b1;
            pvld_q[sel_p]         <= 1'b1;
          end
          step_q <= step_q + 1'b1;
          if (step_q == (LOGN+1)'(N_IN - 1)) state_q <= S_COMMIT;
        end
        S_COMMIT: begin
          for (int p = 0; p < N_IN; p++) begin
            if (pvld_q[p]) free_q[col[p]][route[p*MW +: MW]] <= 1'b0;
            t_row[box_q][p] <= route[p*MW +: MW];
            t_col[box_q][p] <= col[p];
          end
          t_vld[box_q] <= pvld_q;
          done    <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/clos_box_router_chk.sv
module clos_box_router_chk #(
  parameter int N_IN = 4,
  parameter int M = 5,
  parameter int MW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [N_IN*MW-1:0] route
);

  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r2_busy_cause: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (busy || done));
  a_r3_route_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> ($stable(route) && $stable(err)));

  for (genvar a = 0; a < N_IN; a++) begin : g_a
    a_r4_row_range: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (route[a*MW +: MW] < MW'(M)));
    for (genvar b = a + 1; b < N_IN; b++) begin : g_b
      a_r4_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (route[a*MW +: MW] != route[b*MW +: MW]));
    end
  end

endmodule

bind clos_box_router clos_box_router_chk #(.N_IN(N_IN), .M(M), .MW(MW)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .err(err), .route(route)
);

// File: tb/test_clos_box_router.sv
module test_clos_box_router;
  localparam int N_IN = 4;
  localparam int DW = 4;
  localparam int MW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] box = '0;
  logic [N_IN*DW-1:0] dest = '0;
  logic busy, done, err;
  logic [N_IN*MW-1:0] route;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  clos_box_router #(.N_IN(N_IN)) i_clos_box_router (
    .clk(clk), .rst_n(rst_n), .start(start), .box(box), .dest(dest),
    .busy(busy), .done(done), .err(err), .route(route)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] dv(int d0, int d1, int d2, int d3);
    return {4'(d3), 4'(d2), 4'(d1), 4'(d0)};
  endfunction

  function automatic logic [11:0] rv(int r0, int r1, int r2, int r3);
    return {3'(r3), 3'(r2), 3'(r1), 3'(r0)};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Issue one request; optionally pulse start again while busy (R3).
  task automatic run(string req, int b, logic [15:0] d, logic [11:0] exp_r, int exp_e, bit poke);
    int edges = 0;
    bit seen = 0;
    @(negedge clk);
    box = 2'(b); dest = d; start = 1'b1;
    @(posedge clk); edges++;
    @(negedge clk);
    start = 1'b0;
    check({req, " R2 busy after accept"}, int'(busy), 1);
    if (poke) begin
      box = 2'(b + 1); dest = dv(15, 15, 15, 15); start = 1'b1;
      @(posedge clk); edges++;
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < 40 && !seen; k++) begin
      @(posedge clk); edges++;
      @(negedge clk);
      if (done) seen = 1;
    end
    check({req, " R2 done latency"}, edges - 1, N_IN + 2);
    check({req, " R2 busy low at done"}, int'(busy), 0);
    check({req, " route"}, int'(route), int'(exp_r));
    check({req, " R10 err"}, int'(err), exp_e);
    @(negedge clk);
    check({req, " R2 done one cycle"}, int'(done), 0);
    if (poke) begin
      check({req, " R3 no second request"}, int'(busy), 0);
      check({req, " R3 route held"}, int'(route), int'(exp_r));
    end
  endtask

  task automatic t_reset();
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 err", int'(err), 0);
  endtask

  initial begin
    do_reset();
    t_reset();
    // R6 R11: box0 to output boxes 0,1,2,3; ties by pin order (R5)
    run("R6 box0 spread", 0, dv(0, 4, 8, 12), rv(0, 4, 1, 3), 0, 1);
    // R4 R7: box1 avoids box0 paths
    run("R7 box1 pairs", 1, dv(1, 2, 5, 6), rv(1, 2, 3, 0), 0, 0);
    // R5: pins with two alternatives routed before pins with more
    run("R5 box2 mixed", 2, dv(8, 13, 3, 7), rv(0, 4, 3, 2), 0, 0);
    do_reset();
    t_reset();
    // R1: fresh map, all four pins to output box 0
    run("R1 fresh column", 0, dv(0, 1, 2, 3), rv(0, 1, 2, 3), 0, 0);
    // R5: pin1 has a single alternative and must go before pin0
    run("R5 fewest first", 1, dv(4, 0, 9, 14), rv(3, 4, 0, 2), 0, 0);
    // R10: output box 0 fully used by boxes 0 and 1
    run("R10 blocked", 2, dv(0, 1, 2, 3), rv(0, 0, 0, 0), 1, 0);
    // R8: box0 reroute gets back its own freed rows
    run("R8 release", 0, dv(0, 1, 2, 3), rv(0, 1, 2, 3), 0, 0);
    // R9: box1 reroute sees box0 paths still occupied
    run("R9 neighbour kept", 1, dv(4, 0, 9, 14), rv(3, 4, 0, 2), 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule